// File: doc/BRIEF.md
# NAND Bus Phase Timing Generator

This block runs one asynchronous NAND bus cycle at a time. A request names the target space (data, command or address), the direction, which of the chip enables to use and the byte or 16-bit word to write. The block then walks three timed phases, setup, strobe and hold, and drives the chip enable, the command and address latch enables, the write and read strobes and the output enable of the data pads. A one-cycle completion pulse closes each cycle.

Two programmable timing sets exist. Data transfers use the common set; command and address bytes use the attribute set. Each set holds a setup count, a strobe count, a hold count and a turnaround count that keeps the data pads released at the start of a write. A small write port programs both sets and the bus width. Read data is sampled on the clock edge that ends the strobe phase.

Top module: `nand_phase_gen`

## Requirements
- R1: After reset both timing sets read as 0x0a0a0a0a (10 cycles per field), the bus is 8 bits wide, all chip enables are high, both latch enables and the output enable are low, both strobes are high, and busy and done are low.
- R2: A configuration write with cfg_addr 0 loads the common set, cfg_addr 1 loads the attribute set, and cfg_addr 2 loads the bus width from cfg_wdata bit 0 (1 = 16 bits). In a timing word, setup sits in bits 7:0, strobe in 15:8, hold in 23:16 and turnaround in 31:24.
- R3: An accepted request starts its setup phase on the next cycle; setup lasts S cycles with strobes high, then the strobe phase lasts W cycles with the strobe low, then hold lasts H cycles with strobes high. A programmed 0 in S, W or H counts as 1.
- R4: done is high for exactly the one cycle after the hold phase, with all bus pins idle; busy is high from the first setup cycle through that done cycle and low on the next.
- R5: Space code 0 (and 3) is data and uses the common set; code 1 (command) and code 2 (address) use the attribute set.
- R6: Code 1 raises the command latch enable and code 2 the address latch enable for the whole cycle; a data access raises neither. Command and address accesses are always writes, whatever req_write says.
- R7: Only the chip enable indexed by req_cs is low, from the first setup cycle to the last hold cycle.
- R8: On a write the output enable stays low for the first Z+1 cycles of the access (Z is the raw turnaround field, 0 allowed), then stays high until hold ends; it is never high on a read.
- R9: On a read, rd_data takes nand_dq_in as sampled on the last strobe cycle, and holds it until the next read.
- R10: In 8-bit width the upper byte of nand_dq_out and of captured read data is zero; in 16-bit width all bits pass.
- R11: A request is accepted only while the block is idle; requests presented during any phase or during the done cycle are ignored.
- R12: The timing set and bus width are captured when a request is accepted; configuration writes during a cycle do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 common set, 1 attribute set, 2 bus width |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_space | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_write | input | 1 | 1 write, 0 read (data space only) |
| req_cs | input | CS_W | Chip enable index |
| req_wdata | input | DQ_W | Write data |
| nand_dq_in | input | DQ_W | Data pads, input side |
| nand_ce_n | output | N_CS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DQ_W | Data pads, output side |
| nand_dq_oe | output | 1 | Data pad output enable |
| rd_data | output | DQ_W | Captured read data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume the request index names an existing chip enable and that reset is applied before the first clock edge; the stimulus only draws req_cs from 0 and 1 and holds rst_n low at time zero. They also take for granted that nothing outside the block drives the pins, so every property reasons from phase state alone. The sweep applies requests only while idle, except in the directed runs that deliberately present requests and configuration writes mid-cycle, where the pin checks show them ignored.

// File: rtl/nand_phase_pkg.sv
package nand_phase_pkg;
   localparam int TF_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_WAIT  = 3'd2,
      PH_HOLD  = 3'd3,
      PH_DONE  = 3'd4
   } phase_e;

   localparam logic [1:0] SP_DATA = 2'd0;
   localparam logic [1:0] SP_CMD  = 2'd1;
   localparam logic [1:0] SP_ADDR = 2'd2;

   typedef struct packed {
      logic [TF_W-1:0] hiz;
      logic [TF_W-1:0] hold;
      logic [TF_W-1:0] wt;
      logic [TF_W-1:0] setup;
   } timing_t;

   // counter load for a phase; 0 behaves as a one-cycle phase
   function automatic logic [TF_W-1:0] phase_load(input logic [TF_W-1:0] f);
      return (f == '0) ? '0 : f - 1'b1;
   endfunction
endpackage

// File: rtl/nand_tim_regs.sv
module nand_tim_regs
   import nand_phase_pkg::*;
#(
   parameter logic [31:0] RST_TIMING = 32'h0a0a0a0a,
   parameter bit          WIDE_EN    = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output timing_t     tim_common,
   output timing_t     tim_attr,
   output logic        wide
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_common <= timing_t'(RST_TIMING);
         tim_attr   <= timing_t'(RST_TIMING);
      end else if (cfg_we) begin
         if (cfg_addr == 2'd0) tim_common <= timing_t'(cfg_wdata);
         if (cfg_addr == 2'd1) tim_attr   <= timing_t'(cfg_wdata);
      end
   end

   generate
      if (WIDE_EN) begin : g_width_reg
         logic wide_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           wide_q <= 1'b0;
            else if (cfg_we && cfg_addr == 2'd2)  wide_q <= cfg_wdata[0];
         end
         assign wide = wide_q;
      end else begin : g_width_fixed
         assign wide = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
   import nand_phase_pkg::*;
#(
   parameter int EL_W = TF_W + 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  timing_t         tim,
   output phase_e          phase,
   output logic [EL_W-1:0] elapsed,
   output logic            last_wait,
   output logic [TF_W-1:0] hiz
);
   timing_t         tim_q;
   logic [TF_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         elapsed <= '0;
         tim_q   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase   <= PH_SETUP;
                  cnt     <= phase_load(tim.setup);
                  tim_q   <= tim;
                  elapsed <= '0;
               end
            end
            PH_SETUP: begin
               elapsed <= elapsed + 1'b1;
               if (cnt == '0) begin
                  phase <= PH_WAIT;
                  cnt   <= phase_load(tim_q.wt);
               end else cnt <= cnt - 1'b1;
            end
            PH_WAIT: begin
               elapsed <= elapsed + 1'b1;
               if (cnt == '0) begin
                  phase <= PH_HOLD;
                  cnt   <= phase_load(tim_q.hold);
               end else cnt <= cnt - 1'b1;
            end
            PH_HOLD: begin
               elapsed <= elapsed + 1'b1;
               if (cnt == '0) phase <= PH_DONE;
               else           cnt   <= cnt - 1'b1;
            end
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign last_wait = (phase == PH_WAIT) && (cnt == '0);
   assign hiz       = tim_q.hiz;
endmodule

// File: rtl/nand_pin_drv.sv
module nand_pin_drv
   import nand_phase_pkg::*;
#(
   parameter int N_CS = 2,
   parameter int CS_W = 1,
   parameter int DQ_W = 16,
   parameter int EL_W = TF_W + 2
)(
   input  phase_e          phase,
   input  logic [EL_W-1:0] elapsed,
   input  logic [TF_W-1:0] hiz,
   input  logic [1:0]      space_q,
   input  logic            wr_q,
   input  logic [CS_W-1:0] cs_q,
   input  logic [DQ_W-1:0] wdata_q,
   input  logic            wide_q,
   input  logic [DQ_W-1:0] dq_in,
   output logic [N_CS-1:0] ce_n,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic [DQ_W-1:0] dq_out,
   output logic            dq_oe,
   output logic [DQ_W-1:0] rd_cap
);
   logic active, strobe;

   assign active = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
   assign strobe = (phase == PH_WAIT);

   generate
      for (genvar i = 0; i < N_CS; i++) begin : g_ce
         assign ce_n[i] = !(active && (cs_q == CS_W'(i)));
      end
   endgenerate

   assign cle   = active && (space_q == SP_CMD);
   assign ale   = active && (space_q == SP_ADDR);
   assign we_n  = !(strobe && wr_q);
   assign re_n  = !(strobe && !wr_q);
   assign dq_oe = active && wr_q && (elapsed > EL_W'(hiz));

   generate
      if (DQ_W > 8) begin : g_wide_path
         assign dq_out = wide_q ? wdata_q : {{(DQ_W-8){1'b0}}, wdata_q[7:0]};
         assign rd_cap = wide_q ? dq_in   : {{(DQ_W-8){1'b0}}, dq_in[7:0]};
      end else begin : g_byte_path
         assign dq_out = wdata_q;
         assign rd_cap = dq_in;
      end
   endgenerate
endmodule

// File: rtl/nand_phase_gen.sv
module nand_phase_gen
   import nand_phase_pkg::*;
#(
   parameter int          N_CS       = 2,
   parameter int          DQ_W       = 16,
   parameter bit          WIDE_EN    = 1'b1,
   parameter logic [31:0] RST_TIMING = 32'h0a0a0a0a,
   parameter int          CS_W       = (N_CS > 1) ? $clog2(N_CS) : 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   input  logic            req_valid,
   input  logic [1:0]      req_space,
   input  logic            req_write,
   input  logic [CS_W-1:0] req_cs,
   input  logic [DQ_W-1:0] req_wdata,
   input  logic [DQ_W-1:0] nand_dq_in,
   output logic [N_CS-1:0] nand_ce_n,
   output logic            nand_cle,
   output logic            nand_ale,
   output logic            nand_we_n,
   output logic            nand_re_n,
   output logic [DQ_W-1:0] nand_dq_out,
   output logic            nand_dq_oe,
   output logic [DQ_W-1:0] rd_data,
   output logic            busy,
   output logic            done
);
   localparam int EL_W = TF_W + 2;

   generate
      if (N_CS < 1 || N_CS > 16) begin : g_bad_cs
         $error("N_CS out of range");
      end
      if (DQ_W != 8 && DQ_W != 16) begin : g_bad_dq
         $error("DQ_W must be 8 or 16");
      end
      if (WIDE_EN && DQ_W == 8) begin : g_bad_wide
         $error("WIDE_EN needs DQ_W of 16");
      end
   endgenerate

   timing_t         tim_common, tim_attr, tim_sel;
   logic            wide_cfg;
   phase_e          phase;
   logic [EL_W-1:0] elapsed;
   logic            last_wait;
   logic [TF_W-1:0] hiz;
   logic            start, is_attr;
   logic [1:0]      space_q;
   logic            wr_q, wide_q;
   logic [CS_W-1:0] cs_q;
   logic [DQ_W-1:0] wdata_q, rd_cap;

   nand_tim_regs #(.RST_TIMING(RST_TIMING), .WIDE_EN(WIDE_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .tim_common(tim_common), .tim_attr(tim_attr),
      .wide(wide_cfg)
   );

   assign is_attr = (req_space == SP_CMD) || (req_space == SP_ADDR);
   assign tim_sel = is_attr ? tim_attr : tim_common;
   assign start   = req_valid && (phase == PH_IDLE);

   nand_phase_seq #(.EL_W(EL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .tim(tim_sel),
      .phase(phase), .elapsed(elapsed), .last_wait(last_wait), .hiz(hiz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         space_q <= SP_DATA;
         wr_q    <= 1'b0;
         cs_q    <= '0;
         wdata_q <= '0;
         wide_q  <= 1'b0;
      end else if (start) begin
         space_q <= req_space;
         wr_q    <= req_write || is_attr;
         cs_q    <= req_cs;
         wdata_q <= req_wdata;
         wide_q  <= wide_cfg;
      end
   end

   nand_pin_drv #(.N_CS(N_CS), .CS_W(CS_W), .DQ_W(DQ_W), .EL_W(EL_W)) u_pins (
      .phase(phase), .elapsed(elapsed), .hiz(hiz), .space_q(space_q),
      .wr_q(wr_q), .cs_q(cs_q), .wdata_q(wdata_q), .wide_q(wide_q),
      .dq_in(nand_dq_in), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
      .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
      .dq_oe(nand_dq_oe), .rd_cap(rd_cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rd_data <= '0;
      else if (last_wait && !wr_q) rd_data <= rd_cap;
   end

   assign busy = (phase != PH_IDLE);
   assign done = (phase == PH_DONE);
endmodule

// File: rtl/nand_phase_chk.sv
module nand_phase_chk #(
   parameter int N_CS = 2
)(
   input logic            clk,
   input logic            rst_n,
   input logic [N_CS-1:0] nand_ce_n,
   input logic            nand_cle,
   input logic            nand_ale,
   input logic            nand_we_n,
   input logic            nand_re_n,
   input logic            nand_dq_oe,
   input logic            busy,
   input logic            done
);
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r4_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   a_r11_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   a_r7_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n));
   a_r7_ce_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&nand_ce_n));
   a_r6_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));
   a_r3_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !(&nand_ce_n));
   a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);
   a_r4_done_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((&nand_ce_n) && !nand_dq_oe && nand_we_n && nand_re_n));
endmodule

bind nand_phase_gen nand_phase_chk #(.N_CS(N_CS)) u_chk (.*);

// File: tb/sim_nand_phase_gen.sv
module sim_nand_phase_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_space = '0;
   logic        req_write = 1'b0;
   logic [0:0]  req_cs = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] nand_dq_in = '0;
   logic [1:0]  nand_ce_n;
   logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [15:0] nand_dq_out, rd_data;
   logic        busy, done;

   int vectors = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   nand_phase_gen u0 (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int eff(input int f);
      return (f == 0) ? 1 : f;
   endfunction

   // One access; caller is at a negedge. tb = {hiz,hold,wait,setup} of the set used.
   task automatic access(input int sp, input bit wr, input bit cs, input logic [15:0] wd,
                         input logic [15:0] rdv, input logic [31:0] tb, input bit wide,
                         input bit disturb);
      int s, w, h, z, t;
      bit wre;
      logic [8:0] exp_pins;
      s = eff(int'(tb[7:0])); w = eff(int'(tb[15:8])); h = eff(int'(tb[23:16]));
      z = int'(tb[31:24]); t = s + w + h;
      wre = wr || sp == 1 || sp == 2;
      req_valid = 1'b1; req_space = 2'(sp); req_write = wr; req_cs = cs; req_wdata = wd;
      nand_dq_in = rdv;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k <= t + 1; k++) begin
         // sample
         if (k < t) begin
            exp_pins[8:7] = cs ? 2'b01 : 2'b10;
            exp_pins[6]   = (sp == 1);
            exp_pins[5]   = (sp == 2);
            exp_pins[4]   = !(wre && k >= s && k < s + w);
            exp_pins[3]   = !(!wre && k >= s && k < s + w);
            exp_pins[2]   = wre && (k > z);
            exp_pins[1:0] = 2'b10;
            check($sformatf("R3 R5 R6 R7 R8 R11 R12 pins k=%0d sp=%0d", k, sp),
                  {23'd0, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n,
                   nand_dq_oe, busy, done}, {23'd0, exp_pins});
            if (wre && k == t - 1)
               check("R10 write data", {16'd0, nand_dq_out},
                     {16'd0, wide ? wd : {8'd0, wd[7:0]}});
         end else if (k == t) begin
            check("R4 done cycle", {23'd0, nand_ce_n, nand_cle, nand_ale, nand_we_n,
                  nand_re_n, nand_dq_oe, busy, done}, {23'd0, 9'b11_0_0_1_1_0_1_1});
         end else begin
            check("R4 R11 idle after done", {30'd0, busy, done}, 32'd0);
            if (!wre)
               check("R9 R10 read capture", {16'd0, rd_data},
                     {16'd0, wide ? rdv : {8'd0, rdv[7:0]}});
         end
         // drive
         if (k == s + w) nand_dq_in = ~rdv;
         if (disturb) begin
            if (k == 1) begin
               req_valid = 1'b1; req_cs = ~cs; req_space = 2'd2; req_write = ~wr;
               req_wdata = ~wd;
            end
            if (k == 2) begin
               req_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0101ff01;
            end
            if (k == 3) begin cfg_addr = 2'd1; cfg_wdata = 32'h01ff0101; end
            if (k == 4) begin cfg_addr = 2'd2; cfg_wdata = {31'd0, ~wide}; end
            if (k == 5) cfg_we = 1'b0;
            if (k == t) req_valid = 1'b1;
            if (k == t + 1) req_valid = 1'b0;
         end
         if (k <= t) @(negedge clk);
      end
      if (disturb) begin
         req_valid = 1'b0; cfg_we = 1'b0;
      end
   endtask

   initial begin
      logic [31:0] ta, tb;
      int idx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state of pins
      check("R1 idle pins", {23'd0, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n,
            nand_dq_oe, busy, done}, {23'd0, 9'b11_0_0_1_1_0_0_0});
      check("R1 rd_data reset", {16'd0, rd_data}, 32'd0);
      // R1: default timing 10/10/10 turnaround 10, 8-bit width
      access(0, 1'b1, 1'b0, 16'hA55A, 16'h0, 32'h0a0a0a0a, 1'b0, 1'b0);
      access(1, 1'b0, 1'b1, 16'h1234, 16'h0, 32'h0a0a0a0a, 1'b0, 1'b0);
      access(0, 1'b0, 1'b1, 16'h0, 16'hBEEF, 32'h0a0a0a0a, 1'b0, 1'b0);
      // R2: sweep of field values over both sets, both widths
      idx = 0;
      for (int z = 0; z < 2; z++)
         for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
               for (int h = 0; h < 4; h++) begin
                  if (s == 2 || w == 2 || h == 2) continue;
                  ta = {8'(z * 4), 8'(h), 8'(w), 8'(s)};
                  tb = {8'(z * 4 + 1), 8'(s + 1), 8'(h), 8'(w)};
                  cfg_write(2'd0, ta);
                  cfg_write(2'd1, tb);
                  for (int sp = 0; sp < 4; sp++)
                     for (int wr = 0; wr < 2; wr++) begin
                        if (sp == 3 && wr == 1) continue;
                        cfg_write(2'd2, {31'd0, 1'((idx / 2) % 2)});
                        access(sp, 1'(wr), 1'(idx % 2), 16'(16'hC3A5 ^ idx),
                               16'(16'h5A3C + idx * 7),
                               (sp == 1 || sp == 2) ? tb : ta,
                               1'((idx / 2) % 2), 1'b0);
                        idx++;
                     end
               end
      // R11 R12: requests and config writes during a cycle are ignored
      cfg_write(2'd0, 32'h00020202);
      cfg_write(2'd1, 32'h03020202);
      cfg_write(2'd2, 32'd1);
      access(0, 1'b1, 1'b0, 16'hF00D, 16'h0, 32'h00020202, 1'b1, 1'b1);
      cfg_write(2'd0, 32'h00020202);
      cfg_write(2'd1, 32'h03020202);
      cfg_write(2'd2, 32'd1);
      access(0, 1'b0, 1'b1, 16'h0, 16'h8421, 32'h00020202, 1'b1, 1'b1);
      cfg_write(2'd1, 32'h03020202);
      cfg_write(2'd2, 32'd1);
      access(1, 1'b0, 1'b0, 16'h0070, 16'h0, 32'h03020202, 1'b1, 1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule